// File: doc/BRIEF.md
# Return Address Stack with Repeat Counters

This block predicts return addresses for a fetch front end. When a call is predicted, the front end pushes the address of the instruction that follows the call. When a return is predicted, the front end pops the stack. The address it returns is `top_addr_o` in the cycle of the pop. A call counts as a jump-and-link whose destination register is x1 or x5. A return counts as a register jump whose source register is x1 or x5. That decoding is done outside the block.

Each slot holds an address and a small repeat counter. Recursive calls that push the same return address therefore share one slot instead of filling the stack.

The current top entry is kept in a register. The slot array is written one cycle after each operation, from a pending-write register. Reads of the slot below the top check that pending write first.

Recovery works as follows. The owner saves `sp_o`, `occ_o` and the top entry alongside each prediction. It hands them back on `rec_i` to restore the stack. A push or pop given in the same cycle acts on the restored state. This puts back an entry that was popped by mistake, or removes one that should have been popped.

Top module: `ras_repeat_stack`

## Requirements
- R1: After reset, `sp_o` = 0, `occ_o` = 0, `top_addr_o` = 0 and `top_cnt_o` = 0.
- R2: A push on an empty stack, or a push whose address differs from the top, does the following. It advances `sp_o` by one modulo DEPTH, makes the pushed address the top with count 0, and raises `occ_o` by one, saturating at DEPTH.
- R3: A push whose address equals the top on a non-empty stack, with the top count below its maximum, raises the top count by one and leaves `sp_o` and `occ_o` unchanged.
- R4: A push equal to the top while the top count is at its maximum (7 with CNT_W = 3) allocates a new slot with count 0. The saturated slot stays below it, intact.
- R5: A pop with a non-zero top count lowers the count by one and leaves `sp_o`, `occ_o` and `top_addr_o` unchanged.
- R6: A pop with top count 0 and `occ_o` > 1 does three things. It lowers `sp_o` by one modulo DEPTH and lowers `occ_o` by one. The slot below, with its stored count, becomes the top.
- R7: A pop with top count 0 and `occ_o` = 1 lowers `sp_o` and sets `occ_o` to 0, but keeps the top value. A pop on an empty stack changes nothing.
- R8: A push onto a full stack (`occ_o` = DEPTH) wraps and overwrites the oldest slot, and `occ_o` stays at DEPTH.
- R9: When push and pop are given in the same cycle, the pop is applied first and the push then acts on the result.
- R10: With `rec_i` high, `sp_o`, `occ_o` and the top entry are loaded from `rec_sp_i`, `rec_occ_i`, `rec_addr_i` and `rec_cnt_i`. A push or pop in the same cycle then acts on the restored state.
- R11: A slot written in the previous cycle is read correctly by a pop in the next cycle, served from the pending write before it reaches the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request |
| push_addr_i | input | ADDR_W | Return address to push |
| pop_i | input | 1 | Pop request |
| rec_i | input | 1 | Restore state from the snapshot inputs |
| rec_sp_i | input | PTR_W | Snapshot stack pointer |
| rec_occ_i | input | OCC_W | Snapshot occupancy |
| rec_addr_i | input | ADDR_W | Snapshot top address |
| rec_cnt_i | input | CNT_W | Snapshot top count |
| top_addr_o | output | ADDR_W | Current top address (returned value of a pop) |
| top_cnt_o | output | CNT_W | Current top repeat count |
| sp_o | output | PTR_W | Stack pointer, saved by the owner as a snapshot |
| occ_o | output | OCC_W | Number of live slots, saved by the owner as a snapshot |

## Verification
Every state change shows on `top_addr_o`, `top_cnt_o`, `sp_o` and `occ_o` one cycle after the request. A wrong counter or pointer update is therefore visible right away. A corrupted slot below the top stays hidden until enough pops bring that slot to the top, so the bench drains stacks it has built: after repeated pushes, after wrap-around and after counter saturation. A missing pending-write forward shows only when a pop reads the slot written in the cycle before, which a recovery followed by a pop provokes.

// File: rtl/ras_repeat_stack.sv
module ras_repeat_stack #(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 3,
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [ADDR_W-1:0]          push_addr_i,
  input  logic                       pop_i,
  input  logic                       rec_i,
  input  logic [$clog2(DEPTH)-1:0]   rec_sp_i,
  input  logic [$clog2(DEPTH+1)-1:0] rec_occ_i,
  input  logic [ADDR_W-1:0]          rec_addr_i,
  input  logic [CNT_W-1:0]           rec_cnt_i,
  output logic [ADDR_W-1:0]          top_addr_o,
  output logic [CNT_W-1:0]           top_cnt_o,
  output logic [$clog2(DEPTH)-1:0]   sp_o,
  output logic [$clog2(DEPTH+1)-1:0] occ_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int OCC_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH-1);
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [ADDR_W-1:0] mem_addr [DEPTH];
  logic [CNT_W-1:0]  mem_cnt  [DEPTH];

  logic [PTR_W-1:0]  sp_q, wr_ptr_q;
  logic [OCC_W-1:0]  occ_q;
  logic [ADDR_W-1:0] top_addr_q, wr_addr_q;
  logic [CNT_W-1:0]  top_cnt_q, wr_cnt_q;
  logic              wr_v_q;

  logic [PTR_W-1:0]  b_sp, p_sp, n_sp, rd_ptr;
  logic [OCC_W-1:0]  b_occ, p_occ, n_occ;
  logic [ADDR_W-1:0] b_addr, p_addr, n_addr, rd_addr;
  logic [CNT_W-1:0]  b_cnt, p_cnt, n_cnt, rd_cnt;
  logic              rd_hit;

  assign b_sp   = rec_i ? rec_sp_i   : sp_q;
  assign b_occ  = rec_i ? rec_occ_i  : occ_q;
  assign b_addr = rec_i ? rec_addr_i : top_addr_q;
  assign b_cnt  = rec_i ? rec_cnt_i  : top_cnt_q;

  assign rd_ptr  = (b_sp == '0) ? PTR_LAST : b_sp - PTR_W'(1);
  assign rd_hit  = wr_v_q && (wr_ptr_q == rd_ptr);
  assign rd_addr = rd_hit ? wr_addr_q : mem_addr[rd_ptr];
  assign rd_cnt  = rd_hit ? wr_cnt_q  : mem_cnt[rd_ptr];

  always_comb begin
    p_sp = b_sp; p_occ = b_occ; p_addr = b_addr; p_cnt = b_cnt;
    if (pop_i && b_occ != '0) begin
      if (b_cnt != '0) begin
        p_cnt = b_cnt - CNT_W'(1);
      end else begin
        p_sp  = rd_ptr;
        p_occ = b_occ - OCC_W'(1);
        if (b_occ != OCC_W'(1)) begin
          p_addr = rd_addr;
          p_cnt  = rd_cnt;
        end
      end
    end
    n_sp = p_sp; n_occ = p_occ; n_addr = p_addr; n_cnt = p_cnt;
    if (push_i) begin
      if (p_occ != '0 && push_addr_i == p_addr && p_cnt != CNT_MAX) begin
        n_cnt = p_cnt + CNT_W'(1);
      end else begin
        n_sp   = (p_sp == PTR_LAST) ? '0 : p_sp + PTR_W'(1);
        n_occ  = (p_occ == OCC_FULL) ? p_occ : p_occ + OCC_W'(1);
        n_addr = push_addr_i;
        n_cnt  = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0; occ_q <= '0; top_addr_q <= '0; top_cnt_q <= '0;
      wr_v_q <= 1'b0; wr_ptr_q <= '0; wr_addr_q <= '0; wr_cnt_q <= '0;
    end else begin
      sp_q <= n_sp; occ_q <= n_occ; top_addr_q <= n_addr; top_cnt_q <= n_cnt;
      wr_v_q    <= push_i | pop_i | rec_i;
      wr_ptr_q  <= n_sp;
      wr_addr_q <= n_addr;
      wr_cnt_q  <= n_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_v_q) begin
      mem_addr[wr_ptr_q] <= wr_addr_q;
      mem_cnt[wr_ptr_q]  <= wr_cnt_q;
    end
  end

  assign top_addr_o = top_addr_q;
  assign top_cnt_o  = top_cnt_q;
  assign sp_o       = sp_q;
  assign occ_o      = occ_q;

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_o <= OCC_FULL); // R8
  AST_NEW_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !pop_i && !rec_i && (occ_o == '0 || push_addr_i != top_addr_o)
    |=> top_cnt_o == '0 && top_addr_o == $past(push_addr_i)); // R2
  AST_SAME_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !pop_i && !rec_i && occ_o != '0 && push_addr_i == top_addr_o && top_cnt_o != CNT_MAX
    |=> $stable(sp_o) && top_cnt_o == $past(top_cnt_o) + CNT_W'(1)); // R3
  AST_POP_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !push_i && !rec_i && occ_o != '0 && top_cnt_o != '0
    |=> $stable(sp_o) && $stable(top_addr_o) && top_cnt_o == $past(top_cnt_o) - CNT_W'(1)); // R5
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !push_i && !rec_i && occ_o == '0
    |=> $stable(sp_o) && $stable(top_addr_o) && $stable(occ_o)); // R7
  AST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_i && !push_i && !pop_i
    |=> sp_o == $past(rec_sp_i) && occ_o == $past(rec_occ_i)
        && top_addr_o == $past(rec_addr_i) && top_cnt_o == $past(rec_cnt_i)); // R10
endmodule

// File: tb/sim_ras_repeat_stack.sv
module sim_ras_repeat_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, rec_i = 1'b0;
  logic [31:0] push_addr_i = '0, rec_addr_i = '0;
  logic [3:0]  rec_sp_i = '0;
  logic [4:0]  rec_occ_i = '0;
  logic [2:0]  rec_cnt_i = '0;
  logic [31:0] top_addr_o;
  logic [2:0]  top_cnt_o;
  logic [3:0]  sp_o;
  logic [4:0]  occ_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ras_repeat_stack u0 (
    .clk, .rst_n, .push_i, .push_addr_i, .pop_i, .rec_i,
    .rec_sp_i, .rec_occ_i, .rec_addr_i, .rec_cnt_i,
    .top_addr_o, .top_cnt_o, .sp_o, .occ_o
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic state(string req, logic [31:0] a, int c, int sp, int occ);
    chk(req, "top_addr", top_addr_o, a);
    chk(req, "top_cnt", 32'(top_cnt_o), 32'(c));
    chk(req, "sp", 32'(sp_o), 32'(sp));
    chk(req, "occ", 32'(occ_o), 32'(occ));
  endtask

  task automatic op(bit ps, logic [31:0] a, bit pp);
    push_i = ps; push_addr_i = a; pop_i = pp;
    @(posedge clk); #1;
    push_i = 1'b0; pop_i = 1'b0; rec_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    state("R1", 32'h0, 0, 0, 0);
  endtask

  task automatic t_basic();
    do_reset();
    op(1, 32'h100, 0); state("R2", 32'h100, 0, 1, 1);
    op(1, 32'h100, 0); state("R3", 32'h100, 1, 1, 1);
    op(1, 32'h200, 0); state("R2", 32'h200, 0, 2, 2);
    op(1, 32'h200, 0); state("R3", 32'h200, 1, 2, 2);
    op(0, 0, 1);       state("R5", 32'h200, 0, 2, 2);
    op(0, 0, 1);       state("R6", 32'h100, 1, 1, 1);
    op(0, 0, 1);       state("R5", 32'h100, 0, 1, 1);
    op(0, 0, 1);       state("R7", 32'h100, 0, 0, 0);
    op(0, 0, 1);       state("R7", 32'h100, 0, 0, 0);
    op(1, 32'h100, 0); state("R2", 32'h100, 0, 1, 1);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 8; i++) op(1, 32'h300, 0);
    state("R4", 32'h300, 7, 1, 1);
    op(1, 32'h300, 0); state("R4", 32'h300, 0, 2, 2);
    op(0, 0, 1);       state("R4", 32'h300, 7, 1, 1);
  endtask

  task automatic t_wrap();
    do_reset();
    for (int i = 1; i <= 17; i++) op(1, 32'h1000 + 32'(i) * 4, 0);
    state("R8", 32'h1000 + 17 * 4, 0, 1, 16);
    for (int i = 0; i < 15; i++) op(0, 0, 1);
    state("R8", 32'h1000 + 2 * 4, 0, 2, 1);
  endtask

  task automatic t_push_pop();
    do_reset();
    op(1, 32'hA0, 0);
    op(1, 32'hB0, 0);
    op(1, 32'hC0, 1); state("R9", 32'hC0, 0, 2, 2);
    op(1, 32'hA0, 1); state("R9", 32'hA0, 1, 1, 1);
  endtask

  task automatic t_recover();
    do_reset();
    op(1, 32'hA0, 0); op(1, 32'hB0, 0); op(1, 32'hC0, 0);
    rec_i = 1'b1; rec_sp_i = 4'd1; rec_occ_i = 5'd1; rec_addr_i = 32'hA0; rec_cnt_i = 3'd2;
    op(0, 0, 0); state("R10", 32'hA0, 2, 1, 1);
    rec_i = 1'b1; rec_sp_i = 4'd5; rec_occ_i = 5'd3; rec_addr_i = 32'hD0; rec_cnt_i = 3'd0;
    op(1, 32'hD0, 0); state("R10", 32'hD0, 1, 5, 3);
  endtask

  task automatic t_bypass();
    do_reset();
    op(1, 32'hE0, 0);
    rec_i = 1'b1; rec_sp_i = 4'd2; rec_occ_i = 5'd2; rec_addr_i = 32'hF0; rec_cnt_i = 3'd0;
    op(0, 0, 1); state("R11", 32'hE0, 0, 1, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_saturate();
    t_wrap();
    t_push_pop();
    t_recover();
    t_bypass();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule